// File: doc/BRIEF.md
# Masked Binary Correlation Stage with Double-Buffered Patterns

This block is one 32-tap stage of a binary correlator. On every clock a 1-bit sample enters a sample shift register. Each tap compares its stored sample bit with an active reference bit and is gated by an active mask bit. The stage reports how many taps are both enabled and matching, as a registered count from 0 to the tap count.

New reference and mask patterns are shifted in one bit per strobe into two preload registers. Each preload register has its own strobe, and loading does not disturb the patterns in use. A synchronous active-low transfer input copies both preload registers into the active registers in one cycle, while sampling and scoring carry on without a pause.

The oldest sample bit and the oldest preload reference and mask bits are brought out. Several stages can therefore be chained into a longer window, both while streaming and while loading patterns.

Top module: `corr_stage`

## Requirements
- R1: After reset the match count, the sample tail, the reference tail and the mask tail are 0. All active mask bits are 0, so the count stays 0 until the first transfer, whatever samples arrive.
- R2: Tap i scores 1 exactly when the sample captured i edges before the newest one equals active reference bit i and active mask bit i is 1. The count is the number of scoring taps, from 0 to 32. Reference bit i is the bit loaded i strobes before the last load preceding the transfer.
- R3: A tap whose active mask bit is 0 contributes 0 whatever its sample and reference bits are. An all-zero active mask gives a count of 0.
- R4: Each cycle with ref_load high shifts ref_bit into position 0 of the reference preload register, moves every other bit up by one position and drops the bit in the top position. ref_tail shows the top position. Without the strobe, the register holds.
- R5: The mask preload register behaves the same way under mask_load and mask_bit, independently of the reference strobe. mask_tail shows its top position.
- R6: A rising edge with xfer_n low copies both preload registers into the active registers. The sample register keeps shifting in that same cycle.
- R7: The active registers keep their contents while xfer_n is high. Preload strobes without a transfer leave the match count unchanged for the same samples.
- R8: When a load strobe and a transfer fall in the same cycle, the transfer copies the preload contents from before that load.
- R9: The match count after edge k reflects the sample, reference and mask registers as they stood after edge k-1. sample_tail after edge k is the sample captured at edge k-31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 1 | Data sample shifted in every cycle |
| ref_bit | input | 1 | Serial reference bit for the preload register |
| ref_load | input | 1 | Reference preload shift strobe |
| mask_bit | input | 1 | Serial mask bit for the preload register |
| mask_load | input | 1 | Mask preload shift strobe |
| xfer_n | input | 1 | Active-low transfer of both preload registers to the active registers |
| match_count | output | 6 | Registered number of enabled matching taps |
| sample_tail | output | 1 | Oldest sample bit, for chaining |
| ref_tail | output | 1 | Oldest reference preload bit, for chaining |
| mask_tail | output | 1 | Oldest mask preload bit, for chaining |

## Verification
The hardest case to reach is a full score of 32. It needs every sample position to line up with its own reference bit after a transfer. The stimulus gets there by replaying the bench's copy of the active reference, oldest position first, for exactly 32 cycles, and then the complement of it for a score of 0. The same replay is run after further preload strobes that come without a transfer, which shows that the active patterns did not move. A strobe in the same cycle as a transfer separates the old preload contents from the new.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Width needed to hold a count from 0 to taps inclusive
    function automatic int cnt_width(input int taps);
        return $clog2(taps + 1);
    endfunction

endpackage

// File: rtl/corr_shreg.sv
module corr_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] bits_q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } sr_t;

    sr_t st_d, st_q;

    // Newest bit enters position 0, the oldest leaves from position W-1
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_q = st_q.bits;

endmodule

// File: rtl/corr_active_reg.sv
module corr_active_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer_n,
    input  logic [W-1:0] ref_pre,
    input  logic [W-1:0] mask_pre,
    output logic [W-1:0] ref_act,
    output logic [W-1:0] mask_act
);

    typedef struct packed {
        logic [W-1:0] ref_bits;
        logic [W-1:0] mask_bits;
    } act_t;

    act_t st_d, st_q;

    // The transfer copies the registered preload values, so a load in the
    // same cycle is not seen until the next transfer.
    always_comb begin
        st_d = st_q;
        if (!xfer_n) begin
            st_d.ref_bits  = ref_pre;
            st_d.mask_bits = mask_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_act  = st_q.ref_bits;
    assign mask_act = st_q.mask_bits;

endmodule

// File: rtl/corr_score.sv
module corr_score #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  data_bits,
    input  logic [W-1:0]  ref_bits,
    input  logic [W-1:0]  mask_bits,
    output logic [CW-1:0] count_q
);

    typedef struct packed {
        logic [CW-1:0] count;
    } sc_t;

    sc_t          st_d, st_q;
    logic [W-1:0] tap_hit;

    // One comparison cell per tap: equality gated by the mask
    for (genvar i = 0; i < W; i++) begin : g_tap
        assign tap_hit[i] = ~(data_bits[i] ^ ref_bits[i]) & mask_bits[i];
    end

    always_comb begin
        st_d.count = '0;
        for (int i = 0; i < W; i++) begin
            st_d.count = st_d.count + CW'(tap_hit[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;

endmodule

// File: rtl/corr_stage.sv
module corr_stage
    import corr_pkg::*;
#(
    parameter  int TAPS = 32,
    localparam int CW   = cnt_width(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_in,
    input  logic          ref_bit,
    input  logic          ref_load,
    input  logic          mask_bit,
    input  logic          mask_load,
    input  logic          xfer_n,
    output logic [CW-1:0] match_count,
    output logic          sample_tail,
    output logic          ref_tail,
    output logic          mask_tail
);

    logic [TAPS-1:0] data_vec;
    logic [TAPS-1:0] ref_pre;
    logic [TAPS-1:0] mask_pre;
    logic [TAPS-1:0] ref_act;
    logic [TAPS-1:0] mask_act;

    // Sample register shifts on every clock
    corr_shreg #(.W(TAPS)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (1'b1),
        .bit_in   (sample_in),
        .bits_q   (data_vec)
    );

    corr_shreg #(.W(TAPS)) u_ref_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ref_load),
        .bit_in   (ref_bit),
        .bits_q   (ref_pre)
    );

    corr_shreg #(.W(TAPS)) u_mask_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (mask_load),
        .bit_in   (mask_bit),
        .bits_q   (mask_pre)
    );

    corr_active_reg #(.W(TAPS)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_n   (xfer_n),
        .ref_pre  (ref_pre),
        .mask_pre (mask_pre),
        .ref_act  (ref_act),
        .mask_act (mask_act)
    );

    corr_score #(.W(TAPS), .CW(CW)) u_score (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_bits (data_vec),
        .ref_bits  (ref_act),
        .mask_bits (mask_act),
        .count_q   (match_count)
    );

    assign sample_tail = data_vec[TAPS-1];
    assign ref_tail    = ref_pre[TAPS-1];
    assign mask_tail   = mask_pre[TAPS-1];

endmodule

// File: rtl/corr_stage_chk.sv
module corr_stage_chk #(
    parameter int TAPS = 32,
    parameter int CW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            din,
    input logic            ref_bit,
    input logic            ref_load,
    input logic            mask_bit,
    input logic            mask_load,
    input logic            xfer_n,
    input logic [CW-1:0]   count,
    input logic            data_head,
    input logic [TAPS-1:0] ref_pre,
    input logic [TAPS-1:0] mask_pre,
    input logic [TAPS-1:0] ref_act,
    input logic [TAPS-1:0] mask_act
);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(TAPS));

    // R9
    sample_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> data_head == $past(din));

    // R4
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_load |=> $stable(ref_pre));

    // R4
    ref_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load |=> ref_pre[0] == $past(ref_bit));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_load |=> $stable(mask_pre));

    // R5
    mask_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_load |=> mask_pre[0] == $past(mask_bit));

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_n |=> $stable(ref_act) && $stable(mask_act));

    // R6 and R8: the copy takes the preload contents from before the edge
    transfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_n |=> (ref_act == $past(ref_pre)) && (mask_act == $past(mask_pre)));

    // R3
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_act == '0) |=> count == '0);

endmodule

bind corr_stage corr_stage_chk #(.TAPS(TAPS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (sample_in),
    .ref_bit   (ref_bit),
    .ref_load  (ref_load),
    .mask_bit  (mask_bit),
    .mask_load (mask_load),
    .xfer_n    (xfer_n),
    .count     (match_count),
    .data_head (data_vec[0]),
    .ref_pre   (ref_pre),
    .mask_pre  (mask_pre),
    .ref_act   (ref_act),
    .mask_act  (mask_act)
);

// File: tb/tb_corr_stage.sv
module tb_corr_stage;

    localparam int TAPS = 32;
    localparam int CW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_in = 1'b0;
    logic          ref_bit = 1'b0;
    logic          ref_load = 1'b0;
    logic          mask_bit = 1'b0;
    logic          mask_load = 1'b0;
    logic          xfer_n = 1'b1;
    logic [CW-1:0] match_count;
    logic          sample_tail;
    logic          ref_tail;
    logic          mask_tail;

    always #5 clk = ~clk;

    corr_stage #(.TAPS(TAPS)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_in   (sample_in),
        .ref_bit     (ref_bit),
        .ref_load    (ref_load),
        .mask_bit    (mask_bit),
        .mask_load   (mask_load),
        .xfer_n      (xfer_n),
        .match_count (match_count),
        .sample_tail (sample_tail),
        .ref_tail    (ref_tail),
        .mask_tail   (mask_tail)
    );

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    // Bench reference model of the stage, bit 0 = newest
    logic [TAPS-1:0] m_data = '0, m_rpre = '0, m_mpre = '0, m_ract = '0, m_mact = '0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        int    cnt;
        logic  dt;
        logic  rt;
        logic  mt;
        string tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus, predict and queue the result
    task automatic step(input logic d, input logic rb, input logic rl,
                        input logic mb, input logic ml, input logic xn);
        exp_t e;
        sample_in = d; ref_bit = rb; ref_load = rl;
        mask_bit = mb; mask_load = ml; xfer_n = xn;
        @(posedge clk);
        #1;
        e.cnt = $countones(~(m_data ^ m_ract) & m_mact);
        if (!xn) begin
            m_ract = m_rpre;
            m_mact = m_mpre;
        end
        m_data = {m_data[TAPS-2:0], d};
        if (rl) m_rpre = {m_rpre[TAPS-2:0], rb};
        if (ml) m_mpre = {m_mpre[TAPS-2:0], mb};
        e.dt  = m_data[TAPS-1];
        e.rt  = m_rpre[TAPS-1];
        e.mt  = m_mpre[TAPS-1];
        e.tag = phase;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare each registered result away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " match_count"}, int'(match_count), e.cnt);
            check("R9 sample_tail", int'(sample_tail), int'(e.dt));
            check("R4 ref_tail", int'(ref_tail), int'(e.rt));
            check("R5 mask_tail", int'(mask_tail), int'(e.mt));
        end
    end

    // Replay the active reference so that every tap lines up, or its complement
    task automatic replay(input logic invert);
        logic [TAPS-1:0] pat;
        pat = m_ract;
        for (int j = 0; j < TAPS; j++) begin
            step(pat[TAPS-1-j] ^ invert, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int full_mask;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset match_count", int'(match_count), 0);
        check("R1 reset sample_tail", int'(sample_tail), 0);
        check("R1 reset ref_tail", int'(ref_tail), 0);
        check("R1 reset mask_tail", int'(mask_tail), 0);
        rst_n = 1'b1;

        // R1: every tap masked until the first transfer
        phase = "R1";
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R1 masked after reset", int'(match_count), 0);

        // R4 and R5: independent strobes
        phase = "R4";
        for (int i = 0; i < 5; i++) step(rnd(), 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        phase = "R5";
        for (int i = 0; i < 5; i++) step(rnd(), 1'b0, 1'b0, rnd(), 1'b1, 1'b1);

        // R4: full reference load with random bits, mask all enabled
        phase = "R4";
        for (int i = 0; i < TAPS; i++) step(rnd(), rnd(), 1'b1, 1'b1, 1'b1, 1'b1);

        // R6: transfer while sampling
        phase = "R6";
        step(rnd(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R2: full score and zero score
        phase = "R2";
        replay(1'b0);
        check("R2 full score", int'(match_count), TAPS);
        replay(1'b1);
        check("R2 zero score", int'(match_count), 0);

        // R7: new preload contents without transfer do not change scoring
        phase = "R7";
        for (int i = 0; i < TAPS; i++) step(rnd(), rnd(), 1'b1, rnd(), 1'b1, 1'b1);
        replay(1'b0);
        check("R7 active patterns held", int'(match_count), TAPS);

        // R8: load and transfer in the same cycle
        phase = "R8";
        step(rnd(), ~m_rpre[0], 1'b1, ~m_mpre[0], 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(rnd(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        full_mask = $countones(m_mact);
        replay(1'b0);
        check("R8 pre-load contents transferred", int'(match_count), full_mask);

        // R3: partial mask with random data, then an all-zero mask
        phase = "R3";
        for (int i = 0; i < 64; i++) step(rnd(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < TAPS; i++) step(rnd(), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        step(rnd(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        replay(1'b0);
        check("R3 all masked", int'(match_count), 0);

        // R9 and R2: mixed random traffic
        phase = "R9";
        for (int i = 0; i < 400; i++) begin
            step(rnd(), rnd(), rnd(), rnd() | rnd(), rnd(), ~(rnd() & rnd() & rnd()));
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        finish_run();
    end

endmodule